// File: doc/BRIEF.md
# LIDAR Return Georeferencing Pipeline

This block converts laser range returns into earth-frame X, Y and Z coordinates with fixed-point arithmetic. A pose set is loaded once per batch: the sines and cosines of roll, pitch and yaw, plus the aircraft position and the number of returns in the batch. The block then accepts one return per clock. Each return carries its range and the sine and cosine of its scan angle. Three parallel lanes form the rotated unit vector, scale it by the range and add the aircraft position. Results leave in arrival order.

Attitude and position change far more slowly than returns arrive. The pose is therefore folded into six rotation coefficients in a single setup cycle and held for the whole batch. The returns do not depend on each other, so a five-stage pipeline runs them back to back. A four-state controller sequences idle, coefficient setup, streaming and draining. A new pose can only be taken once every return of the previous batch has left the output.

Top module: `lidar_georef`

## Requirements
- R1: Trig inputs are signed 16-bit with 15 fraction bits, range is unsigned 24-bit, and positions and outputs are signed 32-bit; the final sum wraps modulo 2^32.
- R2: With q(a,b) = (a·b + 2^14) >>> 15 (arithmetic shift), the X lane uses a = q(cy,cr) and b = −(q(cy,q(sr,cp)) + q(sy,sp)).
- R3: The Y lane uses a = q(sy,cr) and b = −(q(sy,q(sr,cp)) + q(cy,sp)).
- R4: The Z lane uses a = −sr and b = −q(cr,cp).
- R5: Each lane outputs ((u·ρ + 2^14) >>> 15) + position, where u = (a·sΘ + b·cΘ + 2^14) >>> 15, ρ is the range and sΘ, cΘ are the scan-angle sine and cosine.
- R6: While streaming with out_ready high, in_ready stays high, so one return is taken every clock.
- R7: With out_ready held high, out_valid equals the input handshake of exactly 5 cycles earlier.
- R8: While out_valid is high and out_ready is low, out_valid and all three coordinates hold their values.
- R9: pose_load is acted on only in the idle state and has no effect at any other time. in_ready is low outside the streaming state.
- R10: Once batch_len returns (1 to 33000) have been accepted, in_ready stays low until all of them have left. batch_done then pulses for one cycle, in the cycle after the last output handshake, and the block returns to idle.
- R11: During and right after reset, in_ready, out_valid and batch_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pose_load | input | 1 | Capture the pose inputs and batch length (idle only) |
| sin_roll | input | 16 | Roll sine, Q1.15 |
| cos_roll | input | 16 | Roll cosine, Q1.15 |
| sin_pitch | input | 16 | Pitch sine, Q1.15 |
| cos_pitch | input | 16 | Pitch cosine, Q1.15 |
| sin_yaw | input | 16 | Yaw sine, Q1.15 |
| cos_yaw | input | 16 | Yaw cosine, Q1.15 |
| ac_x | input | 32 | Aircraft X position |
| ac_y | input | 32 | Aircraft Y position |
| ac_z | input | 32 | Aircraft Z position |
| batch_len | input | 16 | Returns in the batch |
| in_valid | input | 1 | Return offered |
| in_ready | output | 1 | Return accepted when high with in_valid |
| in_range | input | 24 | Measured range |
| in_sin | input | 16 | Scan-angle sine, Q1.15 |
| in_cos | input | 16 | Scan-angle cosine, Q1.15 |
| out_valid | output | 1 | Coordinates present |
| out_ready | input | 1 | Downstream takes coordinates |
| out_x | output | 32 | Earth-frame X |
| out_y | output | 32 | Earth-frame Y |
| out_z | output | 32 | Earth-frame Z |
| batch_done | output | 1 | One-cycle pulse after the last output of a batch |

## Verification
The assertions check on every cycle that held outputs stay put under back-pressure, that out_valid follows the input handshake by five cycles whenever out_ready has been high long enough, and that in_ready is high exactly when streaming without a stall. They also check that batch_done only follows an output handshake. Only the bench scenarios show the numeric results of the three lanes, including rounding at full-scale trig values and wraparound of the position sum. They also show that a pose_load in mid-batch is ignored, that the batch length bounds acceptance down to a single return and up to 33000, and that no output is lost or duplicated.

// File: rtl/lidar_georef.sv
module lidar_georef #(
  parameter int TW = 16,
  parameter int RW = 24,
  parameter int PW = 32,
  parameter int NW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pose_load,
  input  logic signed [TW-1:0] sin_roll,
  input  logic signed [TW-1:0] cos_roll,
  input  logic signed [TW-1:0] sin_pitch,
  input  logic signed [TW-1:0] cos_pitch,
  input  logic signed [TW-1:0] sin_yaw,
  input  logic signed [TW-1:0] cos_yaw,
  input  logic signed [PW-1:0] ac_x,
  input  logic signed [PW-1:0] ac_y,
  input  logic signed [PW-1:0] ac_z,
  input  logic [NW-1:0]        batch_len,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [RW-1:0]        in_range,
  input  logic signed [TW-1:0] in_sin,
  input  logic signed [TW-1:0] in_cos,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [PW-1:0] out_x,
  output logic signed [PW-1:0] out_y,
  output logic signed [PW-1:0] out_z,
  output logic                 batch_done
);
  localparam int FR  = TW - 1;
  localparam int CW  = TW + 2;
  localparam int CW2 = 2 * CW;
  localparam int MW  = CW + TW;
  localparam int MW1 = MW + 1;
  localparam int UW  = CW + 1;
  localparam int SW  = UW + RW + 1;
  localparam logic signed [CW2-1:0] RND_C = {{(CW2-FR){1'b0}}, 1'b1, {(FR-1){1'b0}}};
  localparam logic signed [MW1-1:0] RND_S = {{(MW1-FR){1'b0}}, 1'b1, {(FR-1){1'b0}}};
  localparam logic signed [SW-1:0]  RND_P = {{(SW-FR){1'b0}}, 1'b1, {(FR-1){1'b0}}};

  typedef enum logic [1:0] {IDLE = 2'd0, LOAD_POSE = 2'd1, STREAM = 2'd2, DRAIN = 2'd3} st_t;
  st_t st;

  function automatic logic signed [CW-1:0] qm(input logic signed [CW-1:0] a,
                                              input logic signed [CW-1:0] b);
    logic signed [CW2-1:0] p;
    p = (CW2'(a) * CW2'(b) + RND_C) >>> FR;
    return CW'(p);
  endfunction

  logic signed [TW-1:0] p_sr, p_cr, p_sp, p_cp, p_sy, p_cy;
  logic signed [PW-1:0] pos [3];
  logic [NW-1:0]        p_len, icnt, ocnt;
  logic signed [CW-1:0] ca [3], cb [3], na [3], nb [3], t_rp;

  logic [4:0]           vld;
  logic [RW-1:0]        r1_rng, r2_rng, r3_rng;
  logic signed [TW-1:0] r1_s, r1_c;
  logic signed [MW-1:0] pa [3], pb [3];
  logic signed [MW1-1:0] s3 [3];
  logic signed [UW-1:0] u [3];
  logic signed [SW-1:0] sc [3], s5 [3];
  logic signed [PW-1:0] ox [3];

  wire adv  = !vld[4] || out_ready;
  wire fire = in_valid && in_ready;
  wire ofire = out_valid && out_ready;

  assign in_ready  = (st == STREAM) && adv;
  assign out_valid = vld[4];
  assign out_x = ox[0];
  assign out_y = ox[1];
  assign out_z = ox[2];

  always_comb begin
    t_rp  = qm(CW'(p_sr), CW'(p_cp));
    na[0] = qm(CW'(p_cy), CW'(p_cr));
    nb[0] = -(qm(CW'(p_cy), t_rp) + qm(CW'(p_sy), CW'(p_sp)));
    na[1] = qm(CW'(p_sy), CW'(p_cr));
    nb[1] = -(qm(CW'(p_sy), t_rp) + qm(CW'(p_cy), CW'(p_sp)));
    na[2] = -CW'(p_sr);
    nb[2] = -qm(CW'(p_cr), CW'(p_cp));
    for (int k = 0; k < 3; k++) begin
      s3[k] = MW1'(pa[k]) + MW1'(pb[k]) + RND_S;
      s5[k] = (sc[k] + RND_P) >>> FR;
    end
  end

  always_ff @(posedge clk) begin
    if (st == IDLE && pose_load) begin
      p_sr <= sin_roll;  p_cr <= cos_roll;
      p_sp <= sin_pitch; p_cp <= cos_pitch;
      p_sy <= sin_yaw;   p_cy <= cos_yaw;
      pos[0] <= ac_x; pos[1] <= ac_y; pos[2] <= ac_z;
      p_len <= batch_len;
    end
    if (st == LOAD_POSE) begin
      for (int k = 0; k < 3; k++) begin
        ca[k] <= na[k];
        cb[k] <= nb[k];
      end
    end
    if (adv) begin
      r1_rng <= in_range; r1_s <= in_sin; r1_c <= in_cos;
      r2_rng <= r1_rng;
      r3_rng <= r2_rng;
      for (int k = 0; k < 3; k++) begin
        pa[k] <= MW'(ca[k]) * MW'(r1_s);
        pb[k] <= MW'(cb[k]) * MW'(r1_c);
        u[k]  <= UW'(s3[k] >>> FR);
        sc[k] <= SW'(u[k]) * SW'($signed({1'b0, r3_rng}));
        ox[k] <= pos[k] + PW'(s5[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      vld <= '0;
      icnt <= '0;
      ocnt <= '0;
      batch_done <= 1'b0;
    end else begin
      batch_done <= 1'b0;
      if (adv) vld <= {vld[3:0], fire};
      case (st)
        IDLE: if (pose_load) begin
          icnt <= '0;
          ocnt <= '0;
          st <= LOAD_POSE;
        end
        LOAD_POSE: st <= STREAM;
        STREAM: if (fire) begin
          icnt <= icnt + NW'(1);
          if (icnt == p_len - NW'(1)) st <= DRAIN;
        end
        default: ;
      endcase
      if (ofire) begin
        ocnt <= ocnt + NW'(1);
        if (ocnt == p_len - NW'(1)) begin
          batch_done <= 1'b1;
          st <= IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/lidar_georef_chk.sv
module lidar_georef_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        batch_done,
  input logic [1:0]  st,
  input logic [31:0] out_x,
  input logic [31:0] out_y,
  input logic [31:0] out_z
);
  logic [2:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (!out_ready) run <= '0;
    else if (run != 3'd7) run <= run + 3'd1;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y) && $stable(out_z)));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run >= 3'd5) |-> (out_valid == $past(in_valid && in_ready, 5)));

  p_stream_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (st == 2'd2));

  p_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && out_ready) |-> in_ready);

  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> $past(out_valid && out_ready));
endmodule

bind lidar_georef lidar_georef_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .batch_done(batch_done),
  .st(st), .out_x(out_x), .out_y(out_y), .out_z(out_z)
);

// File: tb/lidar_georef_tb_top.sv
module lidar_georef_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 16;
  localparam int V_R [NV] = '{1000, 1000, 5000, 0, 16777215, 16777215, 1, 250000,
                              123456, 777, 9999999, 42, 65536, 3000000, 8, 16000000};
  localparam int V_S [NV] = '{0, 32767, 23170, 12345, -32768, 32767, -1, -23170,
                              10000, -32768, 0, 1, -16384, 28378, 32767, -5000};
  localparam int V_C [NV] = '{32767, 0, 23170, -3000, -32768, 32767, 1, 23170,
                              -31000, 0, -32768, 1, 28378, -16384, -32768, 7000};
  localparam int P_SR [3] = '{3271, -32768, 0};
  localparam int P_CR [3] = '{32604, -32768, 32767};
  localparam int P_SP [3] = '{-1638, 32767, 0};
  localparam int P_CP [3] = '{32727, -32768, 32767};
  localparam int P_SY [3] = '{16384, -32768, 0};
  localparam int P_CY [3] = '{28378, 32767, 32767};
  localparam int P_X  [3] = '{1000000, 2147418112, 0};
  localparam int P_Y  [3] = '{-2000000, -2147483000, 0};
  localparam int P_Z  [3] = '{3000, 0, 0};

  logic clk = 0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, pose_load, in_valid, in_ready, out_valid, out_ready, batch_done;
  logic signed [15:0] sin_roll, cos_roll, sin_pitch, cos_pitch, sin_yaw, cos_yaw, in_sin, in_cos;
  logic signed [31:0] ac_x, ac_y, ac_z, out_x, out_y, out_z;
  logic [15:0] batch_len;
  logic [23:0] in_range;

  lidar_georef dut_i (
    .clk(clk), .rst_n(rst_n), .pose_load(pose_load),
    .sin_roll(sin_roll), .cos_roll(cos_roll), .sin_pitch(sin_pitch), .cos_pitch(cos_pitch),
    .sin_yaw(sin_yaw), .cos_yaw(cos_yaw), .ac_x(ac_x), .ac_y(ac_y), .ac_z(ac_z),
    .batch_len(batch_len), .in_valid(in_valid), .in_ready(in_ready), .in_range(in_range),
    .in_sin(in_sin), .in_cos(in_cos), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_z(out_z), .batch_done(batch_done)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, outs = 0, cur_len = 0;
  bit rdy_mode = 0, lat_chk = 0, done_seen = 0, hold_pend = 0;
  longint ca [3], cb [3], cpos [3];
  logic [31:0] qx [$], qy [$], qz [$];
  int qc [$];
  logic [31:0] hx, hy, hz;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint q(longint a, longint b);
    return (a * b + 16384) >>> 15;
  endfunction

  function automatic logic [31:0] lane(int k, longint r, longint s, longint c);
    longint u, v;
    u = (ca[k] * s + cb[k] * c + 16384) >>> 15;
    v = (u * r + 16384) >>> 15;
    return 32'(v + cpos[k]);
  endfunction

  task automatic set_model(int p);
    longint t;
    t = q(P_SR[p], P_CP[p]);
    ca[0] = q(P_CY[p], P_CR[p]);  cb[0] = -(q(P_CY[p], t) + q(P_SY[p], P_SP[p]));
    ca[1] = q(P_SY[p], P_CR[p]);  cb[1] = -(q(P_SY[p], t) + q(P_CY[p], P_SP[p]));
    ca[2] = -longint'(P_SR[p]);   cb[2] = -q(P_CR[p], P_CP[p]);
    cpos[0] = P_X[p]; cpos[1] = P_Y[p]; cpos[2] = P_Z[p];
  endtask

  always @(negedge clk) if (rst_n) begin
    if (in_valid && in_ready) begin
      qx.push_back(lane(0, longint'(in_range), longint'(in_sin), longint'(in_cos)));
      qy.push_back(lane(1, longint'(in_range), longint'(in_sin), longint'(in_cos)));
      qz.push_back(lane(2, longint'(in_range), longint'(in_sin), longint'(in_cos)));
      qc.push_back(cyc);
    end
    if (out_valid) begin
      if (hold_pend) begin
        chk(out_x == hx && out_y == hy && out_z == hz, "R8", "held coordinates",
            longint'(out_x), longint'($signed(hx)));
        hold_pend = 0;
      end
      if (out_ready) begin
        if (qx.size() == 0) chk(0, "R10", "unexpected output", 1, 0);
        else begin
          logic [31:0] ex, ey, ez;
          int ic;
          ex = qx.pop_front(); ey = qy.pop_front(); ez = qz.pop_front(); ic = qc.pop_front();
          chk(out_x == ex, "R1 R2 R5", "X lane", longint'(out_x), longint'($signed(ex)));
          chk(out_y == ey, "R1 R3 R5", "Y lane", longint'(out_y), longint'($signed(ey)));
          chk(out_z == ez, "R1 R4 R5", "Z lane", longint'(out_z), longint'($signed(ez)));
          if (lat_chk) chk(cyc - ic == 5, "R7", "latency", cyc - ic, 5);
          outs++;
        end
      end else begin
        hold_pend = 1; hx = out_x; hy = out_y; hz = out_z;
      end
    end else if (hold_pend) begin
      chk(0, "R8", "out_valid dropped while stalled", 0, 1);
      hold_pend = 0;
    end
    if (batch_done) begin
      done_seen = 1;
      chk(outs == cur_len, "R10", "outputs at batch_done", outs, cur_len);
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic load(int p, int len, bit track);
    sin_roll = 16'(P_SR[p]); cos_roll = 16'(P_CR[p]);
    sin_pitch = 16'(P_SP[p]); cos_pitch = 16'(P_CP[p]);
    sin_yaw = 16'(P_SY[p]); cos_yaw = 16'(P_CY[p]);
    ac_x = P_X[p]; ac_y = P_Y[p]; ac_z = P_Z[p];
    batch_len = 16'(len);
    pose_load = 1;
    tick();
    pose_load = 0;
    if (track) begin
      set_model(p);
      cur_len = len; outs = 0; done_seen = 0;
    end
  endtask

  task automatic send(int first, int n, int gap, output int took);
    int start;
    start = cyc;
    for (int i = 0; i < n; i++) begin
      in_valid = 1;
      in_range = 24'(V_R[(first + i) % NV]);
      in_sin = 16'(V_S[(first + i) % NV]);
      in_cos = 16'(V_C[(first + i) % NV]);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
      if (gap > 0) begin
        in_valid = 0;
        repeat (gap) tick();
      end
    end
    took = cyc - start;
  endtask

  task automatic drain_check;
    in_valid = 1;
    repeat (2) begin
      @(negedge clk);
      chk(!in_ready, "R10", "in_ready after last return", in_ready, 0);
    end
    #1 in_valid = 0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 300 && !done_seen; i++) @(negedge clk);
    chk(done_seen, "R10", "batch_done seen", done_seen, 1);
    chk(qx.size() == 0, "R10", "pending outputs", qx.size(), 0);
    @(negedge clk);
    chk(!batch_done, "R10", "batch_done one cycle", batch_done, 0);
    #1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog expired: actual %0d expected below %0d cycles", cyc, 150000);
    summary();
    $finish;
  end

  initial begin
    int took;
    rst_n = 0; pose_load = 0; in_valid = 0; in_range = '0; in_sin = '0; in_cos = '0;
    sin_roll = '0; cos_roll = '0; sin_pitch = '0; cos_pitch = '0; sin_yaw = '0; cos_yaw = '0;
    ac_x = '0; ac_y = '0; ac_z = '0; batch_len = '0; out_ready = 1;
    repeat (3) tick();
    @(negedge clk);
    chk(!in_ready && !out_valid && !batch_done, "R11", "outputs in reset",
        {in_ready, out_valid, batch_done}, 0);
    #1 rst_n = 1;
    tick();
    // R9: idle with a return offered and no pose: nothing is taken
    in_valid = 1;
    repeat (4) begin
      @(negedge clk);
      chk(!in_ready && !out_valid && !batch_done, "R9 R11", "idle without pose",
          {in_ready, out_valid, batch_done}, 0);
    end
    #1 in_valid = 0;

    // batch A: back-to-back, no back-pressure
    rdy_mode = 0; lat_chk = 1;
    load(0, 12, 1);
    send(0, 12, 0, took);
    chk(took == 13, "R6", "cycles for 12 returns", took, 13);
    drain_check();
    wait_done();

    // batch B: back-pressure, gaps, ignored mid-batch pose
    rdy_mode = 1; lat_chk = 0;
    load(1, 10, 1);
    send(3, 5, 1, took);
    load(2, 1, 0);
    send(8, 5, 1, took);
    drain_check();
    wait_done();
    chk(outs == 10, "R9", "batch length after ignored load", outs, 10);
    rdy_mode = 0;
    repeat (3) tick();

    // batch C: single return
    lat_chk = 1;
    load(2, 1, 1);
    send(4, 1, 0, took);
    drain_check();
    wait_done();

    // batch D: largest batch
    load(0, 33000, 1);
    send(0, 33000, 0, took);
    chk(took == 33001, "R6", "cycles for 33000 returns", took, 33001);
    drain_check();
    wait_done();
    chk(outs == 33000, "R10", "outputs in full batch", outs, 33000);

    summary();
    $finish;
  end
endmodule